// File: doc/BRIEF.md
# Reorder Buffer with Branch Rollback and Exception Flush

This block is a circular reorder buffer for an out-of-order core. Decode places instructions into it one per cycle, in program order, at the allocation (tail) pointer and learns the slot number it was given. Functional units later report their results in any order by naming that slot, together with the result value and an exception code. The oldest entry leaves through the commit port, in program order, once its result is present. Only the commit port may change registers or memory.

Two recovery paths exist. When the oldest entry carries a non-zero exception code, the block raises a handler redirect and empties itself by moving the tail pointer back onto the head pointer. When a branch is found to be mispredicted, the tail pointer is moved to the slot just after that branch and every younger entry is discarded. Several branches may be in flight and may resolve in any order. Each pointer carries one extra wrap bit so that a full buffer and an empty buffer can be told apart.

Top module: `rob_ring`

## Requirements
- R1: After reset the buffer is empty: `occupancy` is 0, `alloc_ready` is 1, and neither `cm_valid` nor `exc_redirect` is asserted.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both high) goes to slot `alloc_idx`, which is the oldest slot index plus `occupancy`, modulo the depth. Slot numbers wrap from DEPTH-1 to 0, and `occupancy` rises by one on the next cycle unless an entry also retires.
- R3: `alloc_ready` is low whenever `occupancy` equals DEPTH. A request made while the buffer is full is dropped.
- R4: A completion write (`wb_valid`, `wb_idx`) to a slot in use stores `wb_data` and `wb_cause` and marks that slot executed. Slots may complete in any order. A completion write to a slot not in use has no effect: when that slot is later allocated, it does not commit until it is written again.
- R5: `cm_valid` is high in a cycle exactly when the oldest entry is in use, executed, and has exception code 0. It then presents that entry's slot, opcode, destination flag, destination register and result. At most one entry retires per cycle, and the next entry in order retires no earlier than the following cycle.
- R6: `cm_store_en` is high only together with `cm_valid`, and only for an entry allocated with `alloc_store` = 1. A completed store that is not yet the oldest entry never raises it.
- R7: When the oldest entry is executed with a non-zero exception code, `exc_redirect` is high with `exc_cause` equal to that code and `cm_valid` is low. On the next cycle `occupancy` is 0 and the head slot is unchanged, so the next allocation reuses the faulting slot.
- R8: `br_mispredict` naming a slot in use at age offset d from the oldest entry sets `occupancy` to d+1 on the next cycle, or d if the oldest entry retires in the same cycle. All entries younger than the branch are discarded, and the next allocation goes to the slot after the branch.
- R9: `br_mispredict` naming a slot whose age offset is not below `occupancy` is ignored.
- R10: In a cycle with `exc_redirect` or `br_mispredict` high, `alloc_ready` is low. If both recoveries happen in one cycle, the exception flush wins and the rollback is dropped.
- R11: Mispredicts may arrive for a younger branch first and then an older one, and each one cuts the buffer back to its own branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode offers one instruction |
| alloc_op | input | OP_W | Opcode of the offered instruction |
| alloc_store | input | 1 | Offered instruction writes memory |
| alloc_has_dest | input | 1 | Offered instruction writes a register |
| alloc_dest | input | REG_W | Destination register number |
| alloc_ready | output | 1 | Allocation accepted this cycle if offered |
| alloc_idx | output | log2(DEPTH) | Slot that the next allocation takes |
| wb_valid | input | 1 | Completion write strobe |
| wb_idx | input | log2(DEPTH) | Slot being completed |
| wb_data | input | DATA_W | Result value |
| wb_cause | input | CAUSE_W | Exception code, 0 for none |
| br_mispredict | input | 1 | Branch in slot `br_idx` was mispredicted |
| br_idx | input | log2(DEPTH) | Slot of the mispredicted branch |
| cm_valid | output | 1 | Oldest entry retires this cycle |
| cm_idx | output | log2(DEPTH) | Slot of the oldest entry |
| cm_op | output | OP_W | Opcode of the retiring entry |
| cm_has_dest | output | 1 | Retiring entry writes a register |
| cm_dest | output | REG_W | Destination register of the retiring entry |
| cm_data | output | DATA_W | Result of the retiring entry |
| cm_store_en | output | 1 | Memory write permitted for the retiring store |
| exc_redirect | output | 1 | Oldest entry faulted; redirect fetch to the handler |
| exc_cause | output | CAUSE_W | Exception code of the faulting entry |
| occupancy | output | log2(DEPTH)+1 | Number of entries in use |

## Verification
The directed phases fill the buffer to the brim and then complete slots in a scrambled order. This separates the in-order retirement rule from the executed flag: a completed younger entry must wait behind an incomplete older one. A completion aimed at an empty slot shows whether the executed flag survives into a later allocation. Two rollbacks, first to a young branch and then to an older one, followed by one naming a free slot, show whether the discard range is measured from the head and bounded by occupancy. A fault raised together with a mispredict and an allocation shows the recovery priority. A long pseudo-random phase then mixes wrap-around, retire-during-rollback and stray completions, and every port is compared against a behavioural model on each cycle.

// File: rtl/rob_ring_pkg.sv
package rob_ring_pkg;

  // What the oldest entry does in the current cycle
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_TRAP   = 2'd2
  } head_act_e;

endpackage

// File: rtl/rob_ring_ptrs.sv
module rob_ring_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire,
  input  logic             trap,
  input  logic             rb_fire,
  input  logic [IDX_W-1:0] rb_offset,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic [PTR_W-1:0] occupancy,
  output logic             full
);

  // Pointer arithmetic kept in functions so the bench can restate it
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                input logic inc);
    return p + PTR_W'(inc);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_after(input logic [PTR_W-1:0] base,
                                                 input logic [IDX_W-1:0] off);
    return base + PTR_W'(off) + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dist(input logic [PTR_W-1:0] hi,
                                                input logic [PTR_W-1:0] lo);
    return hi - lo;
  endfunction

  assign occupancy = ptr_dist(tail_ptr, head_ptr);
  assign full      = (occupancy == PTR_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else if (trap) begin
      tail_ptr <= head_ptr;
    end else begin
      head_ptr <= ptr_step(head_ptr, retire);
      if (rb_fire) tail_ptr <= ptr_after(head_ptr, rb_offset);
      else         tail_ptr <= ptr_step(tail_ptr, alloc_fire);
    end
  end

endmodule

// File: rtl/rob_ring_slot.sv
module rob_ring_slot #(
  parameter int OP_W    = 6,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kill,
  input  logic               alloc_hit,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic               alloc_store,
  input  logic               alloc_has_dest,
  input  logic [REG_W-1:0]   alloc_dest,
  input  logic               wb_hit,
  input  logic [DATA_W-1:0]  wb_data,
  input  logic [CAUSE_W-1:0] wb_cause,
  output logic               busy,
  output logic               done,
  output logic [OP_W-1:0]    op,
  output logic               store,
  output logic               has_dest,
  output logic [REG_W-1:0]   dest,
  output logic [DATA_W-1:0]  data,
  output logic [CAUSE_W-1:0] cause
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      op       <= '0;
      store    <= 1'b0;
      has_dest <= 1'b0;
      dest     <= '0;
      data     <= '0;
      cause    <= '0;
    end else if (kill) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (alloc_hit) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      op       <= alloc_op;
      store    <= alloc_store;
      has_dest <= alloc_has_dest;
      dest     <= alloc_dest;
      cause    <= '0;
    end else if (wb_hit && busy) begin
      done  <= 1'b1;
      data  <= wb_data;
      cause <= wb_cause;
    end
  end

endmodule

// File: rtl/rob_ring_head.sv
module rob_ring_head
  import rob_ring_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               busy,
  input  logic               done,
  input  logic [CAUSE_W-1:0] cause,
  output head_act_e          act
);

  function automatic logic is_fault(input logic [CAUSE_W-1:0] c);
    return c != '0;
  endfunction

  always_comb begin
    act = HEAD_WAIT;
    if (busy && done) act = is_fault(cause) ? HEAD_TRAP : HEAD_RETIRE;
  end

endmodule

// File: rtl/rob_ring.sv
module rob_ring
  import rob_ring_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int OP_W    = 6,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic               alloc_store,
  input  logic               alloc_has_dest,
  input  logic [REG_W-1:0]   alloc_dest,
  output logic               alloc_ready,
  output logic [IDX_W-1:0]   alloc_idx,
  input  logic               wb_valid,
  input  logic [IDX_W-1:0]   wb_idx,
  input  logic [DATA_W-1:0]  wb_data,
  input  logic [CAUSE_W-1:0] wb_cause,
  input  logic               br_mispredict,
  input  logic [IDX_W-1:0]   br_idx,
  output logic               cm_valid,
  output logic [IDX_W-1:0]   cm_idx,
  output logic [OP_W-1:0]    cm_op,
  output logic               cm_has_dest,
  output logic [REG_W-1:0]   cm_dest,
  output logic [DATA_W-1:0]  cm_data,
  output logic               cm_store_en,
  output logic               exc_redirect,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [PTR_W-1:0]   occupancy
);

  // Named internal events
  logic             alloc_fire;
  logic             retire;
  logic             trap;
  logic             rb_fire;
  logic [IDX_W-1:0] br_offset;
  logic             full;
  logic [PTR_W-1:0] head_ptr;
  logic [PTR_W-1:0] tail_ptr;
  logic [IDX_W-1:0] head_idx;
  logic [IDX_W-1:0] tail_idx;
  head_act_e        act;

  // Slot contents
  logic [DEPTH-1:0]   s_busy, s_done, s_store, s_hd;
  logic [OP_W-1:0]    s_op    [DEPTH];
  logic [REG_W-1:0]   s_dest  [DEPTH];
  logic [DATA_W-1:0]  s_data  [DEPTH];
  logic [CAUSE_W-1:0] s_cause [DEPTH];

  assign head_idx = head_ptr[IDX_W-1:0];
  assign tail_idx = tail_ptr[IDX_W-1:0];

  function automatic logic [IDX_W-1:0] age_of(input logic [IDX_W-1:0] slot,
                                              input logic [IDX_W-1:0] oldest);
    return slot - oldest;
  endfunction

  rob_ring_head #(.CAUSE_W(CAUSE_W)) u_head (
    .busy  (s_busy[head_idx]),
    .done  (s_done[head_idx]),
    .cause (s_cause[head_idx]),
    .act   (act)
  );

  assign retire      = (act == HEAD_RETIRE);
  assign trap        = (act == HEAD_TRAP);
  assign br_offset   = age_of(br_idx, head_idx);
  assign rb_fire     = br_mispredict && !trap && (PTR_W'(br_offset) < occupancy);
  assign alloc_ready = !full && !trap && !br_mispredict;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_idx;

  rob_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .retire     (retire),
    .trap       (trap),
    .rb_fire    (rb_fire),
    .rb_offset  (br_offset),
    .head_ptr   (head_ptr),
    .tail_ptr   (tail_ptr),
    .occupancy  (occupancy),
    .full       (full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [IDX_W-1:0] age;
    logic             younger;
    logic             kill;

    assign age     = age_of(IDX_W'(i), head_idx);
    assign younger = rb_fire && (age > br_offset) && (PTR_W'(age) < occupancy);
    assign kill    = trap || younger || (retire && (head_idx == IDX_W'(i)));

    rob_ring_slot #(
      .OP_W(OP_W), .REG_W(REG_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)
    ) u_slot (
      .clk            (clk),
      .rst_n          (rst_n),
      .kill           (kill),
      .alloc_hit      (alloc_fire && (tail_idx == IDX_W'(i))),
      .alloc_op       (alloc_op),
      .alloc_store    (alloc_store),
      .alloc_has_dest (alloc_has_dest),
      .alloc_dest     (alloc_dest),
      .wb_hit         (wb_valid && (wb_idx == IDX_W'(i))),
      .wb_data        (wb_data),
      .wb_cause       (wb_cause),
      .busy           (s_busy[i]),
      .done           (s_done[i]),
      .op             (s_op[i]),
      .store          (s_store[i]),
      .has_dest       (s_hd[i]),
      .dest           (s_dest[i]),
      .data           (s_data[i]),
      .cause          (s_cause[i])
    );
  end

  assign cm_valid     = retire;
  assign cm_idx       = head_idx;
  assign cm_op        = s_op[head_idx];
  assign cm_has_dest  = s_hd[head_idx];
  assign cm_dest      = s_dest[head_idx];
  assign cm_data      = s_data[head_idx];
  assign cm_store_en  = retire && s_store[head_idx];
  assign exc_redirect = trap;
  assign exc_cause    = s_cause[head_idx];

endmodule

// File: rtl/rob_ring_chk.sv
module rob_ring_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             br_mispredict,
  input logic             cm_valid,
  input logic             cm_store_en,
  input logic             exc_redirect,
  input logic [PTR_W-1:0] occupancy,
  input logic             rb_fire,
  input logic [IDX_W-1:0] rb_offset
);

  a_r1_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= PTR_W'(DEPTH));

  a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !cm_valid) |=> occupancy == $past(occupancy) + PTR_W'(1));

  a_r3_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == PTR_W'(DEPTH)) |-> !alloc_ready);

  a_r5_retire_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> occupancy != '0);

  a_r5_retire_xor_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_valid && exc_redirect));

  a_r6_store_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
    cm_store_en |-> cm_valid);

  a_r7_trap_empties: assert property (@(posedge clk) disable iff (!rst_n)
    exc_redirect |=> occupancy == '0);

  a_r8_rollback_size: assert property (@(posedge clk) disable iff (!rst_n)
    rb_fire |=> occupancy == PTR_W'($past(rb_offset)) + PTR_W'(1) - PTR_W'($past(cm_valid)));

  a_r10_trap_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_redirect |-> !alloc_ready);

  a_r10_mispredict_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    br_mispredict |-> !alloc_ready);

  a_r10_trap_beats_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    exc_redirect |-> !rb_fire);

endmodule

bind rob_ring rob_ring_chk #(.DEPTH(DEPTH)) u_rob_ring_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_valid   (alloc_valid),
  .alloc_ready   (alloc_ready),
  .br_mispredict (br_mispredict),
  .cm_valid      (cm_valid),
  .cm_store_en   (cm_store_en),
  .exc_redirect  (exc_redirect),
  .occupancy     (occupancy),
  .rb_fire       (rb_fire),
  .rb_offset     (br_offset)
);

// File: tb/test_rob_ring.sv
module test_rob_ring;

  localparam int DEPTH   = 8;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int DATA_W  = 32;
  localparam int CAUSE_W = 4;
  localparam int IDX_W   = 3;
  localparam int PTR_W   = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               alloc_valid = 1'b0;
  logic [OP_W-1:0]    alloc_op = '0;
  logic               alloc_store = 1'b0;
  logic               alloc_has_dest = 1'b0;
  logic [REG_W-1:0]   alloc_dest = '0;
  logic               alloc_ready;
  logic [IDX_W-1:0]   alloc_idx;
  logic               wb_valid = 1'b0;
  logic [IDX_W-1:0]   wb_idx = '0;
  logic [DATA_W-1:0]  wb_data = '0;
  logic [CAUSE_W-1:0] wb_cause = '0;
  logic               br_mispredict = 1'b0;
  logic [IDX_W-1:0]   br_idx = '0;
  logic               cm_valid;
  logic [IDX_W-1:0]   cm_idx;
  logic [OP_W-1:0]    cm_op;
  logic               cm_has_dest;
  logic [REG_W-1:0]   cm_dest;
  logic [DATA_W-1:0]  cm_data;
  logic               cm_store_en;
  logic               exc_redirect;
  logic [CAUSE_W-1:0] exc_cause;
  logic [PTR_W-1:0]   occupancy;

  always #5 clk = ~clk;

  rob_ring i_rob_ring (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Behavioural model: head index plus entry count, one record per slot
  bit          m_use   [DEPTH];
  bit          m_exec  [DEPTH];
  int          m_op    [DEPTH];
  bit          m_st    [DEPTH];
  bit          m_hd    [DEPTH];
  int          m_dst   [DEPTH];
  logic [31:0] m_data  [DEPTH];
  int          m_cause [DEPTH];
  int          m_head = 0;
  int          m_cnt  = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit av, input int aop, input bit ast, input bit ahd,
                      input int adst, input bit wv, input int widx,
                      input logic [31:0] wdata, input int wcause,
                      input bit bv, input int bidx);
    bit e_trap, e_ret, e_ready, fire, rb;
    int h, d, t, pre_cnt;
    @(negedge clk);
    alloc_valid    = av;
    alloc_op       = OP_W'(aop);
    alloc_store    = ast;
    alloc_has_dest = ahd;
    alloc_dest     = REG_W'(adst);
    wb_valid       = wv;
    wb_idx         = IDX_W'(widx);
    wb_data        = wdata;
    wb_cause       = CAUSE_W'(wcause);
    br_mispredict  = bv;
    br_idx         = IDX_W'(bidx);
    #1;
    h       = m_head;
    pre_cnt = m_cnt;
    e_trap  = (m_cnt > 0) && m_use[h] && m_exec[h] && (m_cause[h] != 0);
    e_ret   = (m_cnt > 0) && m_use[h] && m_exec[h] && (m_cause[h] == 0);
    e_ready = (m_cnt < DEPTH) && !e_trap && !bv;
    chk("R3 R10 alloc_ready", alloc_ready, e_ready);
    chk("R2 alloc_idx", alloc_idx, (h + m_cnt) % DEPTH);
    chk("R2 R8 occupancy", occupancy, m_cnt);
    chk("R5 cm_valid", cm_valid, e_ret);
    chk("R6 cm_store_en", cm_store_en, e_ret && m_st[h]);
    chk("R7 exc_redirect", exc_redirect, e_trap);
    if (e_ret) begin
      chk("R5 cm_idx", cm_idx, h);
      chk("R5 cm_op", cm_op, m_op[h]);
      chk("R5 cm_has_dest", cm_has_dest, m_hd[h]);
      chk("R5 cm_dest", cm_dest, m_dst[h]);
      chk("R5 cm_data", cm_data, m_data[h]);
    end
    if (e_trap) chk("R7 exc_cause", exc_cause, m_cause[h]);
    @(posedge clk);
    fire = av && e_ready;
    d    = (bidx - h + DEPTH) % DEPTH;
    rb   = bv && !e_trap && (d < pre_cnt);
    t    = (h + pre_cnt) % DEPTH;
    if (wv && m_use[widx]) begin
      m_exec[widx]  = 1;
      m_data[widx]  = wdata;
      m_cause[widx] = wcause;
    end
    if (e_trap) begin
      for (int k = 0; k < DEPTH; k++) begin m_use[k] = 0; m_exec[k] = 0; end
      m_cnt = 0;
    end else begin
      if (rb) begin
        for (int k = d + 1; k < pre_cnt; k++) begin
          m_use[(h + k) % DEPTH] = 0;
          m_exec[(h + k) % DEPTH] = 0;
        end
        m_cnt = d + 1;
      end
      if (e_ret) begin
        m_use[h] = 0;
        m_exec[h] = 0;
        m_head = (h + 1) % DEPTH;
        m_cnt--;
      end
      if (fire) begin
        m_use[t] = 1; m_exec[t] = 0; m_op[t] = aop; m_st[t] = ast;
        m_hd[t] = ahd; m_dst[t] = adst; m_cause[t] = 0;
        m_cnt++;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic alloc1(input int op, input bit st, input int dst);
    step(1, op, st, 1, dst, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wb1(input int idx, input logic [31:0] dat, input int cause);
    step(0, 0, 0, 0, 0, 1, idx, dat, cause, 0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    int seed = 32'h1ace_b00c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: empty after reset
    chk("R1 occupancy", occupancy, 0);
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 cm_valid", cm_valid, 0);
    chk("R1 exc_redirect", exc_redirect, 0);

    // R2, R3: fill to the brim, then one request while full
    for (int i = 0; i < DEPTH; i++) alloc1(i + 1, (i % 3) == 0, i + 2);
    alloc1(40, 1, 9);

    // R4, R5, R6: scrambled completion, in-order retirement
    wb1(3, 32'd103, 0);
    wb1(1, 32'd101, 0);
    wb1(6, 32'd106, 0);
    wb1(0, 32'd100, 0);
    wb1(2, 32'd102, 0);
    wb1(7, 32'd107, 0);
    wb1(5, 32'd105, 0);
    wb1(4, 32'd104, 0);
    idle(8);

    // R4: completion to a free slot is dropped
    wb1(0, 32'hdead, 0);
    alloc1(11, 0, 3);
    idle(3);
    wb1(0, 32'd55, 0);
    idle(2);

    // R8, R11: younger branch first, then older; R9: stray slot
    for (int i = 0; i < 6; i++) alloc1(20 + i, i == 2, 10 + i);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, (m_head + 4) % DEPTH);
    step(1, 30, 0, 1, 1, 0, 0, 0, 0, 1, (m_head + 1) % DEPTH);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, (m_head + 5) % DEPTH);
    alloc1(31, 1, 4);
    wb1(m_head, 32'd200, 0);
    wb1((m_head + 1) % DEPTH, 32'd201, 0);
    wb1((m_head + 1) % DEPTH, 32'd202, 0);
    idle(4);

    // R7, R10: fault at head together with mispredict and allocation
    for (int i = 0; i < 4; i++) alloc1(40 + i, 0, 20 + i);
    wb1((m_head + 1) % DEPTH, 32'd300, 5);
    wb1(m_head, 32'd301, 0);
    idle(1);
    step(1, 50, 0, 1, 1, 0, 0, 0, 0, 1, (m_head + 2) % DEPTH);
    alloc1(51, 0, 2);
    wb1(m_head, 32'd302, 0);
    idle(2);

    // Mixed pseudo-random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      r = seed;
      step(r[0] | r[1], r[29:24], r[22], r[23], r[28:24],
           r[2], r[5:3], 32'(r * 7), (r[9:7] == 0) ? int'(r[13:10]) : 0,
           r[17:14] == 0, r[20:18]);
    end
    idle(12);

    finished = 1;
    finish_run();
  end

endmodule